// File: doc/BRIEF.md
# Load/Store-Multiple Address Sequencer

This block drives the memory side of a block data transfer instruction. A caller presents the 32-bit instruction word and the current value of the base register, then raises `start_i` for one cycle. The block decodes the direction, the addressing mode, the write-back request, the privileged-bank flag, the base register number and the 16-bit register list. It then issues one transfer per cycle. Each transfer carries a word address, a register index and a load/store direction. The final transfer carries a completion pulse and, when write-back is requested, the new base value.

Registers always go out in ascending index order to ascending addresses, whatever the direction of the mode. For the two descending modes the block first works out the lowest address from the number of set bits in the list, then counts upward from it. An instruction that does not carry the block-transfer class code, or that has an empty list, is rejected with an error pulse and issues no transfers. Evaluation of the condition field, the register file and the memory lie outside the block. A full-descending stack push is the decrement-before store, and the matching pop is the increment-after load.

Top module: `lsm_addr_seq`

## Requirements
- R1: `start_i` is accepted only in a cycle with `busy_o` low. A start presented while busy, even with a different instruction and base, leaves the running sequence unchanged and is not taken.
- R2: After acceptance, one transfer is issued in each cycle. The first comes in the cycle after the accepting edge. The register indices on `xfer_reg_o` follow the set bits of instruction bits 15:0 (bit i selects register i) in ascending order, with clear bits skipped.
- R3: With bit 24 = 0 and bit 23 = 1 (increment-after), the first address equals the base.
- R4: With bit 24 = 1 and bit 23 = 1 (increment-before), the first address equals base + 4.
- R5: With bit 24 = 0 and bit 23 = 0 (decrement-after), the first address equals base − 4·N + 4, where N is the number of set list bits.
- R6: With bit 24 = 1 and bit 23 = 0 (decrement-before), the first address equals base − 4·N.
- R7: Each transfer after the first has an address 4 above the previous one, modulo 2^32.
- R8: `xfer_load_o` equals instruction bit 20 (1 = load, 0 = store) for every transfer of the instruction.
- R9: When bit 21 is 1, `wb_valid_o` is high in the cycle of the last transfer, with `wb_data_o` = base ± 4·N (+ when bit 23 = 1) and `wb_reg_o` = bits 19:16. When bit 21 is 0, `wb_valid_o` stays low.
- R10: `busy_o` is high from the first through the last transfer cycle and low afterwards. `done_o` is high only in the cycle of the last transfer.
- R11: If bits 27:25 differ from 3'b100 or bits 15:0 are all zero, `err_o` is high for the one cycle after acceptance, and no transfer, `done_o` or `busy_o` follows.
- R12: `xfer_user_o` equals instruction bit 22 for every transfer.
- R13: While reset is asserted, `busy_o`, `xfer_valid_o`, `done_o`, `err_o` and `wb_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an instruction |
| instr_i | input | 32 | Block transfer instruction word |
| base_i | input | AW | Current value of the base register |
| busy_o | output | 1 | A sequence is running |
| xfer_valid_o | output | 1 | A transfer is issued this cycle |
| xfer_addr_o | output | AW | Word address of the transfer |
| xfer_reg_o | output | 4 | Register index of the transfer |
| xfer_load_o | output | 1 | 1 = load from memory, 0 = store |
| xfer_user_o | output | 1 | Transfer targets the unprivileged register bank |
| done_o | output | 1 | Last transfer of the instruction |
| err_o | output | 1 | Instruction rejected |
| wb_valid_o | output | 1 | Base write-back is due |
| wb_data_o | output | AW | Updated base value |
| wb_reg_o | output | 4 | Base register number |

## Verification
The hardest case to reach is a second request arriving in the middle of a run with a different instruction and base on the inputs. The bench creates it by issuing an instruction and then holding the next request high straight away, so it stays pending through every busy cycle and is taken only at the first idle edge. Address wrap below zero in the descending modes needs a small base with a single-register or full list, and these are aimed at directly. A long stream of random lists, modes and occasional malformed words then covers the skipping of clear bits and runs of back-to-back requests.

// File: rtl/lsm_pkg.sv
`timescale 1ns/1ps
package lsm_pkg;

   localparam int LIST_W    = 16;
   localparam int REG_IDX_W = 4;
   localparam int CNT_W     = 5;
   localparam logic [2:0] BLOCK_XFER_CLASS = 3'b100;

   typedef enum logic [1:0] {
      STEP_INC_AFTER  = 2'b00,
      STEP_INC_BEFORE = 2'b01,
      STEP_DEC_AFTER  = 2'b10,
      STEP_DEC_BEFORE = 2'b11
   } step_mode_e;

   // Per-instruction attributes held for the duration of a run
   typedef struct packed {
      logic                 is_load;
      logic                 user_bank;
      logic                 write_back;
      logic [REG_IDX_W-1:0] base_reg;
   } job_attr_t;

   function automatic step_mode_e mode_of(input logic pre, input logic up);
      step_mode_e m;
      case ({up, pre})
         2'b10:   m = STEP_INC_AFTER;
         2'b11:   m = STEP_INC_BEFORE;
         2'b00:   m = STEP_DEC_AFTER;
         default: m = STEP_DEC_BEFORE;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/lsm_field_decode.sv
`timescale 1ns/1ps
module lsm_field_decode
   import lsm_pkg::*;
#(
   parameter int AW         = 32,
   parameter int WORD_BYTES = 4,
   parameter bit POP_TREE   = 1'b1
) (
   input  logic [31:0]       instr_i,
   input  logic [AW-1:0]     base_i,
   output job_attr_t         attr_o,
   output logic [LIST_W-1:0] list_o,
   output logic [AW-1:0]     first_addr_o,
   output logic [AW-1:0]     final_addr_o,
   output logic              legal_o
);

   localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

   logic             unused_cond;
   logic             pre_idx;
   logic             ascend;
   step_mode_e       mode;
   logic [CNT_W-1:0] count;
   logic [AW-1:0]    span;

   // Condition evaluation happens upstream of this block
   assign unused_cond = ^instr_i[31:28];

   assign pre_idx           = instr_i[24];
   assign ascend            = instr_i[23];
   assign attr_o.user_bank  = instr_i[22];
   assign attr_o.write_back = instr_i[21];
   assign attr_o.is_load    = instr_i[20];
   assign attr_o.base_reg   = instr_i[19:16];
   assign list_o            = instr_i[15:0];

   assign mode    = mode_of(pre_idx, ascend);
   assign legal_o = (instr_i[27:25] == BLOCK_XFER_CLASS) && (|list_o);

   // Register count: either a nibble adder tree or a plain serial sum
   generate
      if (POP_TREE) begin : g_pop_tree
         logic [2:0] nib_sum [LIST_W/4];
         for (genvar g = 0; g < LIST_W/4; g++) begin : g_nib
            assign nib_sum[g] = {2'b00, list_o[4*g]}   + {2'b00, list_o[4*g+1]}
                              + {2'b00, list_o[4*g+2]} + {2'b00, list_o[4*g+3]};
         end
         assign count = {2'b00, nib_sum[0]} + {2'b00, nib_sum[1]}
                      + {2'b00, nib_sum[2]} + {2'b00, nib_sum[3]};
      end else begin : g_pop_serial
         always_comb begin
            count = '0;
            for (int i = 0; i < LIST_W; i++) begin
               count = count + {{(CNT_W-1){1'b0}}, list_o[i]};
            end
         end
      end
   endgenerate

   assign span = AW'(int'(count) * WORD_BYTES);

   // Lowest address touched; the sequence always climbs from here
   always_comb begin
      case (mode)
         STEP_INC_AFTER:  first_addr_o = base_i;
         STEP_INC_BEFORE: first_addr_o = base_i + STEP;
         STEP_DEC_AFTER:  first_addr_o = base_i - span + STEP;
         default:         first_addr_o = base_i - span;
      endcase
   end

   assign final_addr_o = ascend ? (base_i + span) : (base_i - span);

endmodule

// File: rtl/lsm_lowest_pick.sv
`timescale 1ns/1ps
module lsm_lowest_pick #(
   parameter int W       = 16,
   parameter bit ISOLATE = 1'b1,
   localparam int IDX_W  = $clog2(W)
) (
   input  logic [W-1:0]     mask_i,
   output logic [W-1:0]     onehot_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             last_o
);

   generate
      if (ISOLATE) begin : g_isolate
         // Two's-complement trick isolates the lowest set bit
         assign onehot_o = mask_i & (~mask_i + W'(1));
         always_comb begin
            idx_o = '0;
            for (int i = 0; i < W; i++) begin
               if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
            end
         end
      end else begin : g_priority
         // Scan from the top so the lowest set bit wins
         always_comb begin
            idx_o = '0;
            for (int i = W-1; i >= 0; i--) begin
               if (mask_i[i]) idx_o = IDX_W'(i);
            end
         end
         assign onehot_o = (|mask_i) ? (W'(1) << idx_o) : '0;
      end
   endgenerate

   assign last_o = ((mask_i & ~onehot_o) == '0);

endmodule

// File: rtl/lsm_addr_seq.sv
`timescale 1ns/1ps
module lsm_addr_seq
   import lsm_pkg::*;
#(
   parameter int AW           = 32,
   parameter int WORD_BYTES   = 4,
   parameter bit POP_TREE     = 1'b1,
   parameter bit PICK_ISOLATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [31:0]   instr_i,
   input  logic [AW-1:0] base_i,
   output logic          busy_o,
   output logic          xfer_valid_o,
   output logic [AW-1:0] xfer_addr_o,
   output logic [3:0]    xfer_reg_o,
   output logic          xfer_load_o,
   output logic          xfer_user_o,
   output logic          done_o,
   output logic          err_o,
   output logic          wb_valid_o,
   output logic [AW-1:0] wb_data_o,
   output logic [3:0]    wb_reg_o
);

   localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

   generate
      if (AW < 8 || AW > 64) begin : g_bad_aw
         $error("lsm_addr_seq: AW must lie in 8..64");
      end
      if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("lsm_addr_seq: WORD_BYTES must be a power of two");
      end
   endgenerate

   // Decode of the presented instruction
   job_attr_t         dec_attr;
   logic [LIST_W-1:0] dec_list;
   logic [AW-1:0]     dec_first;
   logic [AW-1:0]     dec_final;
   logic              dec_legal;

   lsm_field_decode #(
      .AW         (AW),
      .WORD_BYTES (WORD_BYTES),
      .POP_TREE   (POP_TREE)
   ) u_decode (
      .instr_i      (instr_i),
      .base_i       (base_i),
      .attr_o       (dec_attr),
      .list_o       (dec_list),
      .first_addr_o (dec_first),
      .final_addr_o (dec_final),
      .legal_o      (dec_legal)
   );

   // Run state
   logic              run_q;
   logic              err_q;
   logic [LIST_W-1:0] left_q;
   logic [AW-1:0]     addr_q;
   logic [AW-1:0]     new_base_q;
   job_attr_t         attr_q;

   logic [LIST_W-1:0]    pick_onehot;
   logic [REG_IDX_W-1:0] pick_idx;
   logic                 pick_last;

   lsm_lowest_pick #(
      .W       (LIST_W),
      .ISOLATE (PICK_ISOLATE)
   ) u_pick (
      .mask_i   (left_q),
      .onehot_o (pick_onehot),
      .idx_o    (pick_idx),
      .last_o   (pick_last)
   );

   logic take;
   assign take = start_i && !run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q      <= 1'b0;
         err_q      <= 1'b0;
         left_q     <= '0;
         addr_q     <= '0;
         new_base_q <= '0;
         attr_q     <= '0;
      end else begin
         err_q <= take && !dec_legal;
         if (take) begin
            if (dec_legal) begin
               run_q      <= 1'b1;
               left_q     <= dec_list;
               addr_q     <= dec_first;
               new_base_q <= dec_final;
               attr_q     <= dec_attr;
            end
         end else if (run_q) begin
            left_q <= left_q & ~pick_onehot;
            addr_q <= addr_q + STEP;
            if (pick_last) run_q <= 1'b0;
         end
      end
   end

   assign busy_o       = run_q;
   assign xfer_valid_o = run_q;
   assign xfer_addr_o  = addr_q;
   assign xfer_reg_o   = pick_idx;
   assign xfer_load_o  = attr_q.is_load;
   assign xfer_user_o  = attr_q.user_bank;
   assign done_o       = run_q && pick_last;
   assign err_o        = err_q;
   assign wb_valid_o   = run_q && pick_last && attr_q.write_back;
   assign wb_data_o    = new_base_q;
   assign wb_reg_o     = attr_q.base_reg;

endmodule

// File: rtl/lsm_seq_chk.sv
`timescale 1ns/1ps
module lsm_seq_chk #(
   parameter int AW         = 32,
   parameter int WORD_BYTES = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          busy_o,
   input logic          xfer_valid_o,
   input logic [AW-1:0] xfer_addr_o,
   input logic [3:0]    xfer_reg_o,
   input logic          xfer_load_o,
   input logic          done_o,
   input logic          err_o,
   input logic          wb_valid_o
);

   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i)); // R1

   AST_REG_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid_o && !done_o) |=> (xfer_valid_o && (xfer_reg_o > $past(xfer_reg_o)))); // R2

   AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid_o && !done_o) |=> (xfer_addr_o == $past(xfer_addr_o) + AW'(WORD_BYTES))); // R7

   AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid_o && !done_o) |=> $stable(xfer_load_o)); // R8

   AST_WB_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid_o |-> done_o); // R9

   AST_DONE_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (xfer_valid_o && busy_o)); // R10

   AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o); // R10

   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!busy_o && !xfer_valid_o && !done_o)); // R11

endmodule

bind lsm_addr_seq lsm_seq_chk #(
   .AW         (AW),
   .WORD_BYTES (WORD_BYTES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .busy_o       (busy_o),
   .xfer_valid_o (xfer_valid_o),
   .xfer_addr_o  (xfer_addr_o),
   .xfer_reg_o   (xfer_reg_o),
   .xfer_load_o  (xfer_load_o),
   .done_o       (done_o),
   .err_o        (err_o),
   .wb_valid_o   (wb_valid_o)
);

// File: tb/sim_lsm_addr_seq.sv
`timescale 1ns/1ps
module sim_lsm_addr_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] instr_i = '0;
   logic [31:0] base_i = '0;
   logic        busy_o, xfer_valid_o, xfer_load_o, xfer_user_o;
   logic        done_o, err_o, wb_valid_o;
   logic [31:0] xfer_addr_o, wb_data_o;
   logic [3:0]  xfer_reg_o, wb_reg_o;

   always #2 clk = ~clk; // 250 MHz

   lsm_addr_seq u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i), .base_i(base_i),
      .busy_o(busy_o), .xfer_valid_o(xfer_valid_o), .xfer_addr_o(xfer_addr_o),
      .xfer_reg_o(xfer_reg_o), .xfer_load_o(xfer_load_o), .xfer_user_o(xfer_user_o),
      .done_o(done_o), .err_o(err_o), .wb_valid_o(wb_valid_o), .wb_data_o(wb_data_o),
      .wb_reg_o(wb_reg_o)
   );

   typedef struct {
      bit          busy, valid, done, err, wb, load, user;
      logic [31:0] addr, wbd;
      int          rg, wbr, atag;
   } ent_t;

   ent_t q[$];
   ent_t cur;
   ent_t idle_e;
   int   n_checks = 0;
   int   n_fail   = 0;
   int   n_acc    = 0;
   int   cyc      = 0;
   bit   r1_phase = 1'b0;

   task automatic chk(input bit ok, input int r, input longint act, input longint exp,
                      input string what);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %0h expected %0h", r, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit p, input bit u, input bit s, input bit w,
                                      input bit l, input logic [3:0] rn,
                                      input logic [15:0] lst, input logic [2:0] cls);
      return {4'hE, cls, p, u, s, w, l, rn, lst};
   endfunction

   // Reference model: expected per-cycle outputs for an accepted instruction
   function automatic void push_job(input logic [31:0] ins, input logic [31:0] b);
      ent_t e;
      int n = 0;
      int j = 0;
      logic [31:0] lo, span, nb;
      bit p, u;
      int mtag;
      for (int i = 0; i < 16; i++) if (ins[i]) n++;
      if (ins[27:25] != 3'b100 || n == 0) begin
         e = idle_e; e.err = 1'b1; q.push_back(e); // R11
         return;
      end
      p = ins[24]; u = ins[23];
      span = 32'(4 * n);
      if (u && !p)      begin lo = b;             mtag = 3; end // R3
      else if (u && p)  begin lo = b + 32'd4;     mtag = 4; end // R4
      else if (!p)      begin lo = b - span + 4;  mtag = 5; end // R5
      else              begin lo = b - span;      mtag = 6; end // R6
      nb = u ? b + span : b - span;
      for (int i = 0; i < 16; i++) begin
         if (ins[i]) begin
            e = idle_e;
            e.busy = 1'b1; e.valid = 1'b1;
            e.addr = lo + 32'(4 * j);
            e.rg = i; e.load = ins[20]; e.user = ins[22];
            e.atag = (j == 0) ? mtag : 7; // R7 for the rest
            e.done = (j == n - 1);
            e.wb   = (j == n - 1) && ins[21];
            e.wbd  = nb; e.wbr = int'(ins[19:16]);
            q.push_back(e);
            j++;
         end
      end
   endfunction

   always @(posedge clk) begin
      if (rst_n && start_i && !cur.busy) begin
         push_job(instr_i, base_i);
         n_acc++;
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         // R13 reset state
         chk(!busy_o && !xfer_valid_o && !done_o && !err_o && !wb_valid_o, 13,
             {busy_o, xfer_valid_o, done_o, err_o, wb_valid_o}, 0, "reset outputs");
      end else begin
         ent_t e;
         if (q.size() > 0) e = q.pop_front();
         else e = idle_e;
         cur = e;
         chk(busy_o == e.busy, r1_phase ? 1 : 10, busy_o, e.busy, "busy");
         chk(xfer_valid_o == e.valid, r1_phase ? 1 : 2, xfer_valid_o, e.valid, "valid");
         chk(done_o == e.done, 10, done_o, e.done, "done");
         chk(err_o == e.err, 11, err_o, e.err, "err");
         chk(wb_valid_o == e.wb, 9, wb_valid_o, e.wb, "wb_valid");
         if (e.valid && xfer_valid_o) begin
            chk(xfer_addr_o == e.addr, e.atag, xfer_addr_o, e.addr, "addr");
            chk(int'(xfer_reg_o) == e.rg, 2, xfer_reg_o, e.rg, "reg index");
            chk(xfer_load_o == e.load, 8, xfer_load_o, e.load, "load dir");
            chk(xfer_user_o == e.user, 12, xfer_user_o, e.user, "user bank");
         end
         if (e.wb && wb_valid_o) begin
            chk(wb_data_o == e.wbd, 9, wb_data_o, e.wbd, "wb data");
            chk(int'(wb_reg_o) == e.wbr, 9, wb_reg_o, e.wbr, "wb reg");
         end
      end
   end

   task automatic issue(input logic [31:0] ins, input logic [31:0] b);
      int a0 = n_acc;
      @(negedge clk);
      start_i = 1'b1; instr_i = ins; base_i = b;
      do begin
         @(posedge clk); #1;
      end while (n_acc == a0);
      start_i = 1'b0;
   endtask

   task automatic drain();
      do @(negedge clk); while (q.size() != 0);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_fail++;
         $display("FAIL R10 watchdog: actual hung expected completion");
         summary();
      end
   end

   initial begin
      idle_e = '{default: 0};
      cur    = idle_e;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R3 increment-after load with write-back
      issue(mk(0, 1, 0, 1, 1, 4'd3, 16'h000F, 3'b100), 32'h0000_1000); drain();
      // R4 increment-before store, sparse list, no write-back
      issue(mk(1, 1, 0, 0, 0, 4'd5, 16'h8001, 3'b100), 32'h0000_2000); drain();
      // R5 decrement-after with write-back
      issue(mk(0, 0, 0, 1, 1, 4'd7, 16'h00F0, 3'b100), 32'h0000_3000); drain();
      // R6 decrement-before full list, user bank (R12), stack push
      issue(mk(1, 0, 1, 1, 0, 4'd13, 16'hFFFF, 3'b100), 32'h0000_4000); drain();
      // R6 single register from base zero wraps below zero
      issue(mk(1, 0, 0, 1, 0, 4'd1, 16'h0001, 3'b100), 32'h0000_0000); drain();
      // R5 full list from a small base wraps
      issue(mk(0, 0, 1, 1, 1, 4'd2, 16'hFFFF, 3'b100), 32'h0000_0010); drain();
      // R3 increment-after crossing the top of the space
      issue(mk(0, 1, 0, 1, 1, 4'd9, 16'h4210, 3'b100), 32'hFFFF_FFF8); drain();
      // R11 empty list, then wrong class code
      issue(mk(1, 1, 0, 1, 1, 4'd0, 16'h0000, 3'b100), 32'h0000_5000); drain();
      issue(mk(1, 1, 0, 1, 1, 4'd0, 16'h00FF, 3'b110), 32'h0000_5000); drain();
      // R1 second request held during a running sequence
      issue(mk(0, 1, 0, 1, 0, 4'd4, 16'h0F0F, 3'b100), 32'h0000_6000);
      r1_phase = 1'b1;
      issue(mk(1, 0, 1, 0, 1, 4'd8, 16'h1111, 3'b100), 32'h0000_7000);
      r1_phase = 1'b0;
      drain();
      // Random stream with back-to-back requests
      for (int k = 0; k < 60; k++) begin
         int unsigned rv = $urandom;
         logic [15:0] lst = 16'($urandom);
         logic [2:0]  cls = ((rv % 10) == 0) ? 3'($urandom) : 3'b100;
         if (rv[8]) lst = lst & 16'($urandom);
         issue(mk(rv[0], rv[1], rv[2], rv[3], rv[4], 4'(rv[15:12]), lst, cls),
               $urandom);
      end
      drain();
      summary();
   end

endmodule